// File: doc/BRIEF.md
# Pin Function Selector with Sleep Override

This block decides, for each pin of a bank, which of four signal sources drives the pad. The four sources are plain GPIO and three peripheral alternates. Two read-write select registers hold one bit each per pin, and together these bits choose the source. A third register, the sleep-control register, works with an external force input that the power controller raises when the chip enters a low-power state. For each pin with a clear sleep-control bit, the force returns the pin to GPIO while the force stays high. A pin with a set sleep-control bit keeps its selected source. When the force drops, every pin goes back to its selected source with no register traffic.

The block has a word-wide write port with a combinational read-back, so software can change one pin by reading, modifying and writing a register. For each pin it outputs the resolved data and output enable, a 2-bit code for the function in effect, and a wake-enable bit that is the inverse of the pin's sleep-control bit.

A small controller holds two named states. RUN is the state after reset: pads follow the select registers. FORCED overrides each pin whose sleep-control bit is clear. There are two transitions. ENTER goes from RUN to FORCED on an edge where the force input is sampled high. LEAVE goes from FORCED to RUN on an edge where it is sampled low. In every other case the controller holds its state.

Top module: `pinmux_bank`

## Requirements
- R1: After reset all three registers read 0. Every pin then reports function code 0 (GPIO), and every wake_en bit is 1.
- R2: For each pin the code is {B bit, A bit}, with the A bit in code bit 0. Code 00 selects GPIO, 01 (A only) alternate A, 10 (B only) alternate B, and 11 alternate C. Pin i reports its code on pad_func[2i+1:2i].
- R3: pad_do[i] and pad_oe[i] equal the data and enable inputs of the source chosen by pin i's function code in effect.
- R4: A write with reg_wr high updates the register selected by reg_addr on the next rising clock edge. Address 0 is the A select, 1 is the B select and 2 is sleep control. reg_rdata returns the stored value of the register addressed by reg_addr, combinationally.
- R5: A write to address 3 changes no register, and address 3 reads as 0.
- R6: force_sleep is registered, so the override starts one clock edge after force_sleep is sampled high. While the override is active, a pin whose sleep-control bit is 0 has function code 00 and follows the GPIO source, whatever its select bits are.
- R7: While the override is active, a pin whose sleep-control bit is 1 keeps the function given by its select bits.
- R8: One clock edge after force_sleep is sampled low, every pin returns to the function given by its select bits, with no register write.
- R9: wake_en[i] is the inverse of sleep-control bit i, and it follows that register one edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 A select, 1 B select, 2 sleep control, 3 reserved) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register |
| force_sleep | input | 1 | Low-power force request |
| gpio_do | input | 32 | GPIO source data per pin |
| gpio_oe | input | 32 | GPIO source output enable per pin |
| alta_do | input | 32 | Alternate A data per pin |
| alta_oe | input | 32 | Alternate A output enable per pin |
| altb_do | input | 32 | Alternate B data per pin |
| altb_oe | input | 32 | Alternate B output enable per pin |
| altc_do | input | 32 | Alternate C data per pin |
| altc_oe | input | 32 | Alternate C output enable per pin |
| pad_do | output | 32 | Resolved pad data |
| pad_oe | output | 32 | Resolved pad output enable |
| pad_func | output | 64 | Function code in effect, 2 bits per pin |
| wake_en | output | 32 | Wake detection enable per pin |

## Verification
Uniform all-ones and all-zero select words put every pin in one function at a time, so each source route is checked alone. Random select, sleep and source words mix all four codes across the bank, which exposes swapped A/B bits or a shifted pin index. Force sequences are run with sleep words that overridden and kept pins share. These show the override acting only on clear sleep bits, starting one edge late, and releasing without writes. Writes to the reserved address, with the force held, show that no register changes and that the register read-back stays correct.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
    typedef enum logic [1:0] {
        FN_GPIO = 2'b00,
        FN_ALTA = 2'b01,
        FN_ALTB = 2'b10,
        FN_ALTC = 2'b11
    } func_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_FORCED = 1'b1
    } force_state_e;

    localparam int unsigned NUM_SRC = 4;
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs #(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NPINS-1:0]  wdata_i,
    output logic [NPINS-1:0]  rdata_o,
    output logic [NPINS-1:0]  sel_a_o,
    output logic [NPINS-1:0]  sel_b_o,
    output logic [NPINS-1:0]  slp_o
);
    localparam logic [ADDR_W-1:0] ADR_SELA = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADR_SELB = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] ADR_SLP  = ADDR_W'(2);

    logic [NPINS-1:0] sel_a_q, sel_b_q, slp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_a_q <= '0;
            sel_b_q <= '0;
            slp_q   <= '0;
        end else if (wr_i) begin
            if (addr_i == ADR_SELA) sel_a_q <= wdata_i;
            if (addr_i == ADR_SELB) sel_b_q <= wdata_i;
            if (addr_i == ADR_SLP)  slp_q   <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADR_SELA) rdata_o = sel_a_q;
        if (addr_i == ADR_SELB) rdata_o = sel_b_q;
        if (addr_i == ADR_SLP)  rdata_o = slp_q;
    end

    assign sel_a_o = sel_a_q;
    assign sel_b_o = sel_b_q;
    assign slp_o   = slp_q;

    // R4
    sel_a_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADR_SELA) |=> (sel_a_o == $past(wdata_i)));

    // R5
    reserved_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i > ADR_SLP) |=> ($stable(sel_a_o) && $stable(sel_b_o) && $stable(slp_o)));
endmodule

// File: rtl/pinmux_force_fsm.sv
module pinmux_force_fsm
    import pinmux_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic force_i,
    output logic forced_o
);
    force_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (force_i)  state_d = ST_FORCED;
            ST_FORCED: if (!force_i) state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    always_comb begin
        forced_o = 1'b0;
        unique case (state_q)
            ST_RUN:    forced_o = 1'b0;
            ST_FORCED: forced_o = 1'b1;
            default:   forced_o = 1'b0;
        endcase
    end

    // R6
    enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> forced_o);

    // R8
    leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !force_i |=> !forced_o);
endmodule

// File: rtl/pinmux_pin.sv
module pinmux_pin
    import pinmux_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_a_i,
    input  logic               sel_b_i,
    input  logic               slp_i,
    input  logic               forced_i,
    input  logic [NUM_SRC-1:0] src_do_i,
    input  logic [NUM_SRC-1:0] src_oe_i,
    output logic               do_o,
    output logic               oe_o,
    output logic [1:0]         func_o
);
    func_e sel_fn, eff_fn;

    always_comb begin
        sel_fn = func_e'({sel_b_i, sel_a_i});
        eff_fn = (forced_i && !slp_i) ? FN_GPIO : sel_fn;
    end

    always_comb begin
        do_o = 1'b0;
        oe_o = 1'b0;
        unique case (eff_fn)
            FN_GPIO: begin do_o = src_do_i[0]; oe_o = src_oe_i[0]; end
            FN_ALTA: begin do_o = src_do_i[1]; oe_o = src_oe_i[1]; end
            FN_ALTB: begin do_o = src_do_i[2]; oe_o = src_oe_i[2]; end
            FN_ALTC: begin do_o = src_do_i[3]; oe_o = src_oe_i[3]; end
            default: begin do_o = 1'b0;        oe_o = 1'b0;        end
        endcase
    end

    assign func_o = eff_fn;

    // R6
    override_gpio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (forced_i && !slp_i) |-> (func_o == 2'b00 && do_o == src_do_i[0] && oe_o == src_oe_i[0]));

    // R7
    keep_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (forced_i && slp_i) |-> (func_o == {sel_b_i, sel_a_i}));
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
    import pinmux_pkg::*;
#(
    parameter int unsigned NPINS  = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic              force_sleep,
    input  logic [NPINS-1:0]  gpio_do,
    input  logic [NPINS-1:0]  gpio_oe,
    input  logic [NPINS-1:0]  alta_do,
    input  logic [NPINS-1:0]  alta_oe,
    input  logic [NPINS-1:0]  altb_do,
    input  logic [NPINS-1:0]  altb_oe,
    input  logic [NPINS-1:0]  altc_do,
    input  logic [NPINS-1:0]  altc_oe,
    output logic [NPINS-1:0]  pad_do,
    output logic [NPINS-1:0]  pad_oe,
    output logic [2*NPINS-1:0] pad_func,
    output logic [NPINS-1:0]  wake_en
);
    logic [NPINS-1:0] sel_a, sel_b, slp;
    logic             forced;

    pinmux_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .sel_a_o (sel_a),
        .sel_b_o (sel_b),
        .slp_o   (slp)
    );

    pinmux_force_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .force_i  (force_sleep),
        .forced_o (forced)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        pinmux_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_a_i  (sel_a[p]),
            .sel_b_i  (sel_b[p]),
            .slp_i    (slp[p]),
            .forced_i (forced),
            .src_do_i ({altc_do[p], altb_do[p], alta_do[p], gpio_do[p]}),
            .src_oe_i ({altc_oe[p], altb_oe[p], alta_oe[p], gpio_oe[p]}),
            .do_o     (pad_do[p]),
            .oe_o     (pad_oe[p]),
            .func_o   (pad_func[2*p +: 2])
        );
    end

    assign wake_en = ~slp;

    // R9
    wake_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_W'(2)) |=> (wake_en == ~$past(reg_wdata)));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |-> (pad_func == '0 && wake_en == '1));
endmodule

// File: tb/test_pinmux_bank.sv
module test_pinmux_bank;
    localparam int N = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_addr = '0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic force_sleep = 1'b0;
    logic [N-1:0] gpio_do = '0, gpio_oe = '0, alta_do = '0, alta_oe = '0;
    logic [N-1:0] altb_do = '0, altb_oe = '0, altc_do = '0, altc_oe = '0;
    logic [N-1:0] pad_do, pad_oe, wake_en;
    logic [2*N-1:0] pad_func;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [N-1:0] m_a = '0, m_b = '0, m_s = '0;
    logic m_forced = 1'b0;

    always #2 clk = ~clk;

    pinmux_bank i_pinmux_bank (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .force_sleep(force_sleep),
        .gpio_do(gpio_do), .gpio_oe(gpio_oe), .alta_do(alta_do), .alta_oe(alta_oe),
        .altb_do(altb_do), .altb_oe(altb_oe), .altc_do(altc_do), .altc_oe(altc_oe),
        .pad_do(pad_do), .pad_oe(pad_oe), .pad_func(pad_func), .wake_en(wake_en)
    );

    task automatic cmp(input string req, input string what, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [2*N-1:0] exp_func();
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++)
            v[2*i +: 2] = (m_forced && !m_s[i]) ? 2'b00 : {m_b[i], m_a[i]};
        return v;
    endfunction

    function automatic logic [N-1:0] exp_pad(input bit want_oe);
        logic [N-1:0] v;
        logic [2*N-1:0] f;
        f = exp_func();
        for (int i = 0; i < N; i++) begin
            case (f[2*i +: 2])
                2'b00: v[i] = want_oe ? gpio_oe[i] : gpio_do[i];
                2'b01: v[i] = want_oe ? alta_oe[i] : alta_do[i];
                2'b10: v[i] = want_oe ? altb_oe[i] : altb_do[i];
                default: v[i] = want_oe ? altc_oe[i] : altc_do[i];
            endcase
        end
        return v;
    endfunction

    function automatic logic [N-1:0] exp_reg(input logic [1:0] a);
        case (a)
            2'd0: return m_a;
            2'd1: return m_b;
            2'd2: return m_s;
            default: return '0;
        endcase
    endfunction

    task automatic step(input logic wr, input logic [1:0] a, input logic [N-1:0] d, input logic frc);
        @(negedge clk);
        reg_wr = wr; reg_addr = a; reg_wdata = d; force_sleep = frc;
        @(posedge clk);
        if (wr) begin
            if (a == 2'd0) m_a = d;
            if (a == 2'd1) m_b = d;
            if (a == 2'd2) m_s = d;
        end
        m_forced = frc;
        #1 reg_wr = 1'b0;
    endtask

    task automatic check_all(input string ftag, input logic [1:0] rd);
        reg_addr = rd;
        #0.5;
        cmp(ftag, "pad_func", pad_func, exp_func());
        cmp("R3", "pad_do", {{N{1'b0}}, pad_do}, {{N{1'b0}}, exp_pad(1'b0)});
        cmp("R3", "pad_oe", {{N{1'b0}}, pad_oe}, {{N{1'b0}}, exp_pad(1'b1)});
        cmp("R9", "wake_en", {{N{1'b0}}, wake_en}, {{N{1'b0}}, ~m_s});
        cmp(rd == 2'd3 ? "R5" : "R4", "rdata", {{N{1'b0}}, reg_rdata}, {{N{1'b0}}, exp_reg(rd)});
    endtask

    task automatic rand_src();
        gpio_do = $urandom; gpio_oe = $urandom; alta_do = $urandom; alta_oe = $urandom;
        altb_do = $urandom; altb_oe = $urandom; altc_do = $urandom; altc_oe = $urandom;
    endtask

    initial begin
        void'($urandom(32'd1234));
        rand_src();
        #9;
        // R1: state under reset
        check_all("R1", 2'd0);
        check_all("R1", 2'd2);
        @(negedge clk) rst_n = 1'b1;
        check_all("R1", 2'd1);

        // R2: one function across the whole bank at a time
        step(1, 2'd0, '1, 0); check_all("R2", 2'd0);
        step(1, 2'd1, '1, 0); check_all("R2", 2'd1);
        step(1, 2'd0, '0, 0); check_all("R2", 2'd0);
        step(1, 2'd1, 32'h0000_FFFF, 0); rand_src(); step(1, 2'd0, 32'h00FF_00FF, 0);
        check_all("R2", 2'd0);

        // R5: reserved address write ignored, reads zero
        step(1, 2'd3, '1, 0); check_all("R5", 2'd3);
        check_all("R5", 2'd0);

        // R6/R7: force with mixed sleep bits
        step(1, 2'd2, 32'hA5A5_0F0F, 0);
        @(negedge clk) force_sleep = 1'b1;
        #0.5 cmp("R6", "pad_func before edge", pad_func, exp_func());
        @(posedge clk) m_forced = 1'b1;
        #1 check_all("R6", 2'd2);
        step(0, 2'd0, '0, 1); check_all("R7", 2'd1);
        step(1, 2'd3, '1, 1); check_all("R5", 2'd2);

        // R8: release without writes
        step(0, 2'd0, '0, 0); check_all("R8", 2'd0);

        // random mix
        for (int k = 0; k < 300; k++) begin
            logic [1:0] a;
            a = 2'($urandom_range(0, 3));
            rand_src();
            step(1'($urandom), a, $urandom, 1'($urandom_range(0, 2) == 0));
            check_all(m_forced ? "R6" : "R2", 2'($urandom_range(0, 3)));
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule